// File: doc/BRIEF.md
# Graphics command packet framer

This block sits on the data side of a graphics command port and takes one 32-bit word per cycle. It groups the words into command packets. The opcode sits in bits 31:24 of the leading word, and the block finds the packet length from that opcode and from flag bits in the same byte.

When a drawing or transfer packet is complete, the block sends the downstream renderer a one-cycle strobe. The strobe carries the opcode and the number of words in the packet. Single-word state commands never reach the renderer. Instead, their fields are decoded straight into the block's own registers: draw mode, mask control, texture window, clip corners and drawing origin.

Length rules:
- Polygons, lines and rectangles have fixed lengths that follow from the texture, shading, quad and size flags.
- A polyline runs until a terminator word appears at a vertex-aligned position.
- An upload from the CPU takes its length from the pixel count in its third word.

A clear input from the control side drops any partly collected packet.

Top module: `cmd_packet_framer`

## Requirements
- R1: Opcodes 0xE1 to 0xE6 are state commands. Each one is a complete packet of one word. It updates its registers on the edge that accepts it and never raises `done_o`.
- R2: A polygon (bits 31:29 = 001; bit 28 shading, bit 27 quad, bit 26 texture) has (1 + texture + shading) × (4 if quad, else 3) words, plus one more when shading is clear.
- R3: A single line (bits 31:29 = 010, bit 27 clear) has 2 × (1 + shading) words, plus one more when shading is clear.
- R4: A polyline (bits 31:29 = 010, bit 27 set) ends on the word 0x55555555, but only at an index i ≥ 1 that is a multiple of (1 + shading). A terminator word at any other index is ordinary data.
- R5: A rectangle (bits 31:29 = 011) has 2 + texture words, plus one more when bits 28:27 are 00 (variable size).
- R6: Fill (0x02) and readback to the CPU (0xC0) are 3 words each.
- R7: An upload from the CPU (0xA0) is 3 + (w × h + 1) / 2 words. Here w is bits 15:0 and h is bits 31:16 of the word at index 2.
- R8: `done_o` is high for exactly the one cycle after the edge that accepts a packet's final word. At that point `done_op` holds the opcode and `done_len` holds the word count. It is low after every other accepted word.
- R9: 0xE1 stores bits 13:0 in `draw_mode`. 0xE6 stores bits 1:0 in `mask_ctl`.
- R10: 0xE2 stores four 5-bit fields: mask x from bits 4:0, mask y from bits 9:5, offset x from bits 14:10, offset y from bits 19:15.
- R11: 0xE3 sets the top-left clip corner and 0xE4 the bottom-right corner. In both, x comes from bits 9:0 and y from bits 18:10.
- R12: 0xE5 sets the drawing origin. x comes from bits 10:0 and y from bits 21:11, each a signed value sign-extended to OFS_W bits.
- R13: The no-op 0x00 and any opcode not listed above are one-word packets. They raise no strobe and change no register.
- R14: After reset, and after `clear_i`, the word counter is zero. A word presented in the same cycle as `clear_i` is discarded. After reset all state outputs are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Drop the partial packet and rewind the counter |
| wr_valid | input | 1 | A command word is present |
| wr_data | input | 32 | Command word |
| done_o | output | 1 | One-cycle packet-complete strobe |
| done_op | output | 8 | Opcode of the completed packet |
| done_len | output | CNT_W | Word count of the completed packet |
| draw_mode | output | 14 | Draw mode field |
| mask_ctl | output | 2 | Mask set / mask test bits |
| win_mask_x | output | 5 | Texture window mask x |
| win_mask_y | output | 5 | Texture window mask y |
| win_off_x | output | 5 | Texture window offset x |
| win_off_y | output | 5 | Texture window offset y |
| clip_x0 | output | 10 | Clip top-left x |
| clip_y0 | output | 9 | Clip top-left y |
| clip_x1 | output | 10 | Clip bottom-right x |
| clip_y1 | output | 9 | Clip bottom-right y |
| org_x | output | OFS_W | Sign-extended drawing origin x |
| org_y | output | OFS_W | Sign-extended drawing origin y |

## Verification
Every result is due one cycle after the clock edge that takes the deciding word:
- the completion strobe with its opcode and count;
- each state register update.

No path inside the block is combinational from input to output. The bench presents each word on the falling edge and reads the outputs one nanosecond after the following rising edge. That way each word's effect is checked in the very cycle it becomes visible. The check also confirms that the strobe stayed low after every word before the last.

// File: rtl/gpkt_pkg.sv
package gpkt_pkg;

    typedef enum logic [1:0] {
        PK_SINGLE = 2'd0,
        PK_FIXED  = 2'd1,
        PK_CHAIN  = 2'd2,
        PK_UPLOAD = 2'd3
    } pk_kind_e;

    typedef struct packed {
        pk_kind_e    kind;
        logic [3:0]  len;        // fixed length; floor for uploads
        logic        pair_step;  // chain terminator only at even index
        logic        strobe;     // completion goes downstream
        logic [7:0]  op;
    } pk_hdr_t;

    localparam logic [31:0] CHAIN_END   = 32'h5555_5555;
    localparam logic [7:0]  OP_FILL     = 8'h02;
    localparam logic [7:0]  OP_UPLOAD   = 8'hA0;
    localparam logic [7:0]  OP_READBACK = 8'hC0;
    localparam logic [7:0]  OP_MODE     = 8'hE1;
    localparam logic [7:0]  OP_WINDOW   = 8'hE2;
    localparam logic [7:0]  OP_CLIP_TL  = 8'hE3;
    localparam logic [7:0]  OP_CLIP_BR  = 8'hE4;
    localparam logic [7:0]  OP_ORIGIN   = 8'hE5;
    localparam logic [7:0]  OP_MASK     = 8'hE6;
    localparam int unsigned UPLOAD_SIZE_IDX = 2;

    // Length class from the leading opcode byte alone.
    function automatic pk_hdr_t decode_head(input logic [7:0] op);
        pk_hdr_t    h;
        logic [3:0] per_v;
        h.op        = op;
        h.kind      = PK_SINGLE;
        h.len       = 4'd1;
        h.pair_step = 1'b0;
        h.strobe    = 1'b0;
        per_v       = 4'd0;
        case (op[7:5])
            3'b001: begin
                per_v    = 4'd1 + {3'b000, op[2]} + {3'b000, op[4]};
                h.len    = per_v * (op[3] ? 4'd4 : 4'd3) + {3'b000, ~op[4]};
                h.kind   = PK_FIXED;
                h.strobe = 1'b1;
            end
            3'b010: begin
                h.strobe = 1'b1;
                if (op[3]) begin
                    h.kind      = PK_CHAIN;
                    h.pair_step = op[4];
                    h.len       = 4'd0;
                end else begin
                    per_v  = 4'd1 + {3'b000, op[4]};
                    h.len  = (per_v << 1) + {3'b000, ~op[4]};
                    h.kind = PK_FIXED;
                end
            end
            3'b011: begin
                h.len    = 4'd2 + {3'b000, op[2]} + {3'b000, (op[4:3] == 2'b00)};
                h.kind   = PK_FIXED;
                h.strobe = 1'b1;
            end
            default: begin
                if (op == OP_FILL || op == OP_READBACK) begin
                    h.kind   = PK_FIXED;
                    h.len    = 4'd3;
                    h.strobe = 1'b1;
                end else if (op == OP_UPLOAD) begin
                    h.kind   = PK_UPLOAD;
                    h.len    = 4'd3;
                    h.strobe = 1'b1;
                end
            end
        endcase
        return h;
    endfunction

    // Total upload length from the size word: 3 + ceil(w*h/2).
    function automatic logic [32:0] upload_words(input logic [31:0] size_w);
        logic [31:0] px;
        px = {16'd0, size_w[15:0]} * {16'd0, size_w[31:16]};
        return (({1'b0, px} + 33'd1) >> 1) + 33'd3;
    endfunction

endpackage

// File: rtl/gpkt_head_dec.sv
module gpkt_head_dec
    import gpkt_pkg::*;
(
    input  logic [7:0] op_i,
    output pk_hdr_t    hdr_o
);
    always_comb hdr_o = decode_head(op_i);
endmodule

// File: rtl/gpkt_seq.sv
module gpkt_seq
    import gpkt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  pk_hdr_t          head_i,
    output logic             first_o,
    output logic             done_o,
    output logic [7:0]       done_op,
    output logic [CNT_W-1:0] done_len
);
    localparam logic [CNT_W-1:0] SIZE_IDX = CNT_W'(UPLOAD_SIZE_IDX);

    logic [CNT_W-1:0] idx_q, tgt_q, tgt_now, next_idx;
    pk_hdr_t          hdr_q, hdr_now;
    logic             acc, at_head, finish;
    logic             done_q;
    logic [7:0]       op_q;
    logic [CNT_W-1:0] len_q;

    assign acc      = wr_valid && !clear_i;
    assign at_head  = (idx_q == '0);
    assign hdr_now  = at_head ? head_i : hdr_q;
    assign next_idx = idx_q + 1'b1;
    assign first_o  = acc && at_head;

    always_comb begin
        if (at_head)
            tgt_now = CNT_W'(head_i.len);
        else if (hdr_q.kind == PK_UPLOAD && idx_q == SIZE_IDX)
            tgt_now = CNT_W'(upload_words(wr_data));
        else
            tgt_now = tgt_q;
    end

    always_comb begin
        case (hdr_now.kind)
            PK_SINGLE: finish = 1'b1;
            PK_CHAIN:  finish = !at_head && (wr_data == CHAIN_END) &&
                                (!hdr_now.pair_step || !idx_q[0]);
            default:   finish = (next_idx == tgt_now);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            tgt_q  <= '0;
            hdr_q  <= '0;
            done_q <= 1'b0;
            op_q   <= '0;
            len_q  <= '0;
        end else begin
            done_q <= acc && finish && hdr_now.strobe;
            if (acc && finish && hdr_now.strobe) begin
                op_q  <= hdr_now.op;
                len_q <= next_idx;
            end
            if (clear_i) begin
                idx_q <= '0;
            end else if (acc) begin
                if (finish) begin
                    idx_q <= '0;
                end else begin
                    idx_q <= next_idx;
                    tgt_q <= tgt_now;
                    if (at_head) hdr_q <= head_i;
                end
            end
        end
    end

    assign done_o   = done_q;
    assign done_op  = op_q;
    assign done_len = len_q;

    // R8: a strobe only ever follows an accepted word
    p_done_after_word_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(acc));
    // R14: clear rewinds the counter
    p_clear_rewinds_r14: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (idx_q == '0));
    // R14: no word, no movement
    p_idle_holds_r14: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && !clear_i) |=> ($stable(idx_q) && !done_q));
    // R1: single-word commands stay silent and leave the counter at zero
    p_single_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && at_head && head_i.kind == PK_SINGLE) |=> (!done_q && idx_q == '0));
    // R7: an upload is never shorter than its header
    p_upload_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (done_q && done_op == OP_UPLOAD) |-> (done_len >= CNT_W'(3)));
    // R4: a chain completes only on its terminator word
    p_chain_on_end_r4: assert property (@(posedge clk) disable iff (rst)
        (done_q && hdr_q.kind == PK_CHAIN) |-> ($past(wr_data) == CHAIN_END));

endmodule

// File: rtl/gpkt_state.sv
module gpkt_state
    import gpkt_pkg::*;
#(
    parameter int unsigned OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply_i,
    input  logic [31:0]      word_i,
    output logic [13:0]      draw_mode,
    output logic [1:0]       mask_ctl,
    output logic [4:0]       win_mask_x,
    output logic [4:0]       win_mask_y,
    output logic [4:0]       win_off_x,
    output logic [4:0]       win_off_y,
    output logic [9:0]       clip_x0,
    output logic [8:0]       clip_y0,
    output logic [9:0]       clip_x1,
    output logic [8:0]       clip_y1,
    output logic [OFS_W-1:0] org_x,
    output logic [OFS_W-1:0] org_y
);
    localparam int unsigned SGN_W = 11;
    localparam int unsigned EXT_W = OFS_W - SGN_W;

    logic [7:0] op;
    logic       unused_bits;
    assign op          = word_i[31:24];
    assign unused_bits = ^word_i[23:22];

    always_ff @(posedge clk) begin
        if (rst) begin
            draw_mode  <= '0;
            mask_ctl   <= '0;
            win_mask_x <= '0;
            win_mask_y <= '0;
            win_off_x  <= '0;
            win_off_y  <= '0;
            clip_x0    <= '0;
            clip_y0    <= '0;
            clip_x1    <= '0;
            clip_y1    <= '0;
            org_x      <= '0;
            org_y      <= '0;
        end else if (apply_i) begin
            case (op)
                OP_MODE:   draw_mode <= word_i[13:0];
                OP_MASK:   mask_ctl  <= word_i[1:0];
                OP_WINDOW: begin
                    win_mask_x <= word_i[4:0];
                    win_mask_y <= word_i[9:5];
                    win_off_x  <= word_i[14:10];
                    win_off_y  <= word_i[19:15];
                end
                OP_CLIP_TL: begin
                    clip_x0 <= word_i[9:0];
                    clip_y0 <= word_i[18:10];
                end
                OP_CLIP_BR: begin
                    clip_x1 <= word_i[9:0];
                    clip_y1 <= word_i[18:10];
                end
                OP_ORIGIN: begin
                    org_x <= {{EXT_W{word_i[10]}}, word_i[10:0]};
                    org_y <= {{EXT_W{word_i[21]}}, word_i[21:11]};
                end
                default: ;
            endcase
        end
    end

    // R13: registers move only when a leading word is applied
    p_quiet_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !apply_i |=> ($stable(draw_mode) && $stable(mask_ctl) && $stable(win_mask_x) &&
                      $stable(win_mask_y) && $stable(win_off_x) && $stable(win_off_y) &&
                      $stable(clip_x0) && $stable(clip_y0) && $stable(clip_x1) &&
                      $stable(clip_y1) && $stable(org_x) && $stable(org_y)));
    // R12: origin upper bits are always a copy of the sign
    p_origin_sign_r12: assert property (@(posedge clk) disable iff (rst)
        (($countones(org_x[OFS_W-1:SGN_W-1]) == 0 || $countones(org_x[OFS_W-1:SGN_W-1]) == EXT_W + 1) &&
         ($countones(org_y[OFS_W-1:SGN_W-1]) == 0 || $countones(org_y[OFS_W-1:SGN_W-1]) == EXT_W + 1)));

endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
    import gpkt_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             done_o,
    output logic [7:0]       done_op,
    output logic [CNT_W-1:0] done_len,
    output logic [13:0]      draw_mode,
    output logic [1:0]       mask_ctl,
    output logic [4:0]       win_mask_x,
    output logic [4:0]       win_mask_y,
    output logic [4:0]       win_off_x,
    output logic [4:0]       win_off_y,
    output logic [9:0]       clip_x0,
    output logic [8:0]       clip_y0,
    output logic [9:0]       clip_x1,
    output logic [8:0]       clip_y1,
    output logic [OFS_W-1:0] org_x,
    output logic [OFS_W-1:0] org_y
);
    pk_hdr_t head;
    logic    first;

    gpkt_head_dec u_dec (
        .op_i  (wr_data[31:24]),
        .hdr_o (head)
    );

    gpkt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_i),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .head_i   (head),
        .first_o  (first),
        .done_o   (done_o),
        .done_op  (done_op),
        .done_len (done_len)
    );

    gpkt_state #(.OFS_W(OFS_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .apply_i    (first),
        .word_i     (wr_data),
        .draw_mode  (draw_mode),
        .mask_ctl   (mask_ctl),
        .win_mask_x (win_mask_x),
        .win_mask_y (win_mask_y),
        .win_off_x  (win_off_x),
        .win_off_y  (win_off_y),
        .clip_x0    (clip_x0),
        .clip_y0    (clip_y0),
        .clip_x1    (clip_x1),
        .clip_y1    (clip_y1),
        .org_x      (org_x),
        .org_y      (org_y)
    );
endmodule

// File: tb/cmd_packet_framer_tb.sv
module cmd_packet_framer_tb;
    localparam int unsigned CNT_W = 32;
    localparam int unsigned OFS_W = 16;
    localparam logic [31:0] END_W = 32'h5555_5555;

    logic clk = 1'b0;
    logic rst, clear_i, wr_valid;
    logic [31:0] wr_data;
    logic done_o;
    logic [7:0] done_op;
    logic [CNT_W-1:0] done_len;
    logic [13:0] draw_mode;
    logic [1:0] mask_ctl;
    logic [4:0] win_mask_x, win_mask_y, win_off_x, win_off_y;
    logic [9:0] clip_x0, clip_x1;
    logic [8:0] clip_y0, clip_y1;
    logic [OFS_W-1:0] org_x, org_y;

    always #5 clk = ~clk;

    cmd_packet_framer #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_dut (
        .clk(clk), .rst(rst), .clear_i(clear_i), .wr_valid(wr_valid), .wr_data(wr_data),
        .done_o(done_o), .done_op(done_op), .done_len(done_len),
        .draw_mode(draw_mode), .mask_ctl(mask_ctl),
        .win_mask_x(win_mask_x), .win_mask_y(win_mask_y), .win_off_x(win_off_x), .win_off_y(win_off_y),
        .clip_x0(clip_x0), .clip_y0(clip_y0), .clip_x1(clip_x1), .clip_y1(clip_y1),
        .org_x(org_x), .org_y(org_y)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] pk [64];

    // bench model of the state registers
    logic [13:0] m_mode;  logic [1:0] m_mask;
    logic [4:0] m_wmx, m_wmy, m_wox, m_woy;
    logic [9:0] m_cx0, m_cx1; logic [8:0] m_cy0, m_cy1;
    logic [15:0] m_ox, m_oy;

    function automatic int exp_len(logic [31:0] w);
        int op, tex, shd, quad;
        op = int'(w[31:24]); tex = int'(w[26]); shd = int'(w[28]); quad = int'(w[27]);
        if (op >= 'h20 && op <= 'h3F) return (1 + tex + shd) * (quad ? 4 : 3) + (shd ? 0 : 1);
        if (op >= 'h40 && op <= 'h5F) return 2 * (1 + shd) + (shd ? 0 : 1);
        if (op >= 'h60 && op <= 'h7F) return 2 + tex + ((w[28:27] == 2'b00) ? 1 : 0);
        if (op == 'h02 || op == 'hC0) return 3;
        return 1;
    endfunction

    function automatic logic [31:0] fill_word();
        logic [31:0] v;
        v = $urandom;
        if (v == END_W) v = 32'h1234_5678;
        return v;
    endfunction

    task automatic model_apply(logic [31:0] w);
        case (w[31:24])
            8'hE1: m_mode = w[13:0];
            8'hE2: begin m_wmx = w[4:0]; m_wmy = w[9:5]; m_wox = w[14:10]; m_woy = w[19:15]; end
            8'hE3: begin m_cx0 = w[9:0]; m_cy0 = w[18:10]; end
            8'hE4: begin m_cx1 = w[9:0]; m_cy1 = w[18:10]; end
            8'hE5: begin m_ox = {{5{w[10]}}, w[10:0]}; m_oy = {{5{w[21]}}, w[21:11]}; end
            8'hE6: m_mask = w[1:0];
            default: ;
        endcase
    endtask

    task automatic check_state(string tag);
        checks++;
        if (draw_mode !== m_mode || mask_ctl !== m_mask || win_mask_x !== m_wmx ||
            win_mask_y !== m_wmy || win_off_x !== m_wox || win_off_y !== m_woy ||
            clip_x0 !== m_cx0 || clip_y0 !== m_cy0 || clip_x1 !== m_cx1 || clip_y1 !== m_cy1 ||
            org_x !== m_ox || org_y !== m_oy) begin
            fails++;
            $display("FAIL %s: state mode=%h mask=%h win=%h/%h/%h/%h clip=%h,%h,%h,%h org=%h,%h expected mode=%h mask=%h win=%h/%h/%h/%h clip=%h,%h,%h,%h org=%h,%h",
                     tag, draw_mode, mask_ctl, win_mask_x, win_mask_y, win_off_x, win_off_y,
                     clip_x0, clip_y0, clip_x1, clip_y1, org_x, org_y,
                     m_mode, m_mask, m_wmx, m_wmy, m_wox, m_woy, m_cx0, m_cy0, m_cx1, m_cy1, m_ox, m_oy);
        end
    endtask

    task automatic put_word(logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    // sends pk[0..n-1]; strobe expected only after the last word (R8)
    task automatic run_pkt(int n, bit exp_done, int exp_n, string tag);
        bit early;
        early = 0;
        for (int i = 0; i < n; i++) begin
            put_word(pk[i]);
            if (i < n - 1 && done_o) early = 1;
        end
        model_apply(pk[0]);
        checks++;
        if (early || done_o !== exp_done ||
            (exp_done && (done_len !== CNT_W'(exp_n) || done_op !== pk[0][31:24]))) begin
            fails++;
            $display("FAIL %s: early=%0b done=%0b len=%0d op=%02h expected done=%0b len=%0d op=%02h",
                     tag, early, done_o, done_len, done_op, exp_done, exp_n, pk[0][31:24]);
        end
        check_state(tag);
    endtask

    task automatic fixed_pkt(logic [31:0] head, string tag);
        int n;
        n = exp_len(head);
        pk[0] = head;
        for (int i = 1; i < n; i++) pk[i] = fill_word();
        run_pkt(n, 1'b1, n, tag);
    endtask

    task automatic upload_pkt(int w, int h);
        int n;
        n = 3 + (w * h + 1) / 2;
        pk[0] = {8'hA0, 24'($urandom)};
        pk[1] = fill_word();
        pk[2] = {16'(h), 16'(w)};
        for (int i = 3; i < n; i++) pk[i] = $urandom;
        run_pkt(n, 1'b1, n, "R7 upload");
    endtask

    // chain of k data words then terminator; stray terminator at odd index if shaded
    task automatic chain_pkt(bit shd, int k, bit stray);
        pk[0] = {3'b010, shd, 1'b1, 3'($urandom), 24'($urandom)};
        for (int i = 1; i <= k; i++) pk[i] = fill_word();
        if (shd && stray) pk[1] = END_W;
        pk[k + 1] = END_W;
        run_pkt(k + 2, 1'b1, k + 2, "R4 polyline");
    endtask

    task automatic single_pkt(logic [31:0] w, string tag);
        pk[0] = w;
        run_pkt(1, 1'b0, 1, tag);
    endtask

    task automatic pulse_clear(bit with_word, logic [31:0] w);
        @(negedge clk);
        clear_i  = 1'b1;
        wr_valid = with_word;
        wr_data  = w;
        @(posedge clk);
        #1;
        clear_i  = 1'b0;
        wr_valid = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] unk [12];
        void'($urandom(32'd20240611));
        unk = '{8'h00, 8'h01, 8'h03, 8'h1F, 8'h80, 8'h9F, 8'hA1, 8'hBF, 8'hC1, 8'hE0, 8'hE7, 8'hFF};
        m_mode = '0; m_mask = '0; m_wmx = '0; m_wmy = '0; m_wox = '0; m_woy = '0;
        m_cx0 = '0; m_cy0 = '0; m_cx1 = '0; m_cy1 = '0; m_ox = '0; m_oy = '0;
        rst = 1'b1; clear_i = 1'b0; wr_valid = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R14 reset state
        checks++;
        if (done_o !== 1'b0) begin
            fails++;
            $display("FAIL R14 reset: done=%0b expected 0", done_o);
        end
        check_state("R14 reset state");

        // R2 polygons
        fixed_pkt(32'h3E00_0000, "R2 polygon shaded quad textured (12)");
        fixed_pkt(32'h2000_0000, "R2 polygon mono tri (4)");
        fixed_pkt(32'h2C00_0000, "R2 polygon quad textured mono (9)");
        fixed_pkt(32'h3800_0000, "R2 polygon shaded quad (8)");
        // R3 lines
        fixed_pkt(32'h4000_0000, "R3 line mono (3)");
        fixed_pkt(32'h5000_0000, "R3 line shaded (4)");
        // R5 rectangles
        fixed_pkt(32'h6000_0000, "R5 rect variable (3)");
        fixed_pkt(32'h6400_0000, "R5 rect variable textured (4)");
        fixed_pkt(32'h6800_0000, "R5 rect fixed size (2)");
        fixed_pkt(32'h7C00_0000, "R5 rect fixed textured (3)");
        // R6
        fixed_pkt(32'h02FF_0000, "R6 fill");
        fixed_pkt(32'hC000_0000, "R6 readback");
        // R7 directed
        upload_pkt(3, 3);
        upload_pkt(0, 9);
        upload_pkt(1, 1);
        // R4 directed: shaded, stray terminator at odd index 1 ignored, ends at 4
        chain_pkt(1'b1, 3, 1'b1);
        chain_pkt(1'b0, 2, 1'b0);
        // R12 sign extension corner
        single_pkt({8'hE5, 2'b00, 11'h7FF, 11'h400}, "R12 origin negative");
        single_pkt({8'hE5, 2'b11, 11'h3FF, 11'h001}, "R12 origin positive");
        // R1/R9/R10/R11 directed
        single_pkt(32'hE1FF_FFFF, "R9 draw mode");
        single_pkt(32'hE600_0002, "R9 mask control");
        single_pkt(32'hE20F_8421, "R10 texture window");
        single_pkt(32'hE3FF_FFFF, "R11 clip top-left");
        single_pkt(32'hE400_0401, "R11 clip bottom-right");
        // R13 nop then a packet must start at its head
        single_pkt(32'h00FF_FFFF, "R13 nop");
        fixed_pkt(32'h4000_0000, "R13 packet after nop");

        // R14 clear mid-packet, then clear with a word in the same cycle
        put_word(32'h2000_0000);
        put_word(32'h1111_1111);
        pulse_clear(1'b0, 32'h0);
        fixed_pkt(32'h4000_0000, "R14 clear mid-packet");
        pulse_clear(1'b1, 32'h3E00_0000);
        fixed_pkt(32'h4000_0000, "R14 word with clear dropped");

        // random mix
        for (int t = 0; t < 400; t++) begin
            int cat;
            cat = $urandom_range(0, 7);
            case (cat)
                0: fixed_pkt({3'b001, 5'($urandom), 24'($urandom)}, "R2 random polygon");
                1: fixed_pkt({3'b010, 1'($urandom), 1'b0, 3'($urandom), 24'($urandom)}, "R3 random line");
                2: begin
                    bit shd;
                    shd = 1'($urandom);
                    if (shd) chain_pkt(1'b1, 2 * $urandom_range(0, 4) + 1, 1'($urandom));
                    else     chain_pkt(1'b0, $urandom_range(0, 8), 1'b0);
                end
                3: fixed_pkt({3'b011, 5'($urandom), 24'($urandom)}, "R5 random rectangle");
                4: fixed_pkt({($urandom_range(0, 1) == 0) ? 8'h02 : 8'hC0, 24'($urandom)}, "R6 random fill/readback");
                5: upload_pkt($urandom_range(0, 7), $urandom_range(0, 7));
                6: single_pkt({8'hE1 + 8'($urandom_range(0, 5)), 24'($urandom)}, "R1 random state command");
                default: single_pkt({unk[$urandom_range(0, 11)], 24'($urandom)}, "R13 random unknown");
            endcase
        end

        finished = 1;
        report();
        $finish;
    end
endmodule